// File: doc/BRIEF.md
# Sigma-Delta Calibration Sequencer

This block is the control core in the digital back end of a sigma-delta converter. A 3-bit mode code arrives through a register write. From then on the block counts output-rate ticks from the decimation filter and steps through measurement phases. In each phase it tells the analog front end which source to present: the external input, an internal zero, or the internal reference. At the end of each phase it takes the filtered result, either as a calibration coefficient or as a conversion result.

Three sequences are supported:
- **Normal conversion.** The filter settles and then produces continuous results.
- **One-step system-offset calibration.** Zero scale is measured on the external input, then full scale on the internal reference. Both coefficients are committed together, the mode code falls back to normal, and one conversion follows.
- **Background calibration.** An internal zero-scale measurement is inserted after every result. This refreshes the offset coefficient continuously at one sixth of the output rate.

Each conversion result is corrected by subtracting the zero-scale coefficient and saturating to the output code range. The result then raises an active-low data-ready flag.

Top module: `sdcal_seq`

## Requirements
- R1: After synchronous reset, the mode readback is 000, the zero-scale coefficient is 0, the full-scale coefficient is 2^(W-1), `drdy_n` is 1 and `data_out` is 0.
- R2: Writing mode code 100 starts a system-offset calibration, and the sequence runs as follows:
  - For three output ticks `meas_src` is 0 (external input). The third result is kept as the zero-scale value.
  - For three more ticks `meas_src` is 2 (internal reference). On the sixth tick both coefficients are committed: full scale takes that tick's result, and the mode readback returns to 000.
- R3: After a system-offset calibration, `drdy_n` stays high through the eighth tick and goes low on the ninth. That ninth tick ends a three-tick conversion on the external input.
- R4: A mode write does not change `drdy_n` at once. `drdy_n` goes high on the first modulator tick after the write, unless a new result arrives first.
- R5: Mode code 101 repeats the following cycle, with one result per six ticks:
  - Three ticks with `meas_src` 1 (internal zero). The third tick loads the zero-scale coefficient.
  - Three conversion ticks with `meas_src` 0. The third tick produces a result.

  The full-scale coefficient never changes in this mode, and the mode stays 101 until the next write.
- R6: `filt_sync` is ignored while the mode is 101. In every other mode it restarts the three-tick settling count of the current phase.
- R7: In unipolar mode (`bipolar`=0), `data_out` = raw − zero-scale, clamped to 0..2^W−1.
- R8: In bipolar mode, `data_out` = raw − zero-scale + 2^(W-1), clamped to 0..2^W−1 (offset binary).
- R9: `rd_strobe` drives `drdy_n` high; a new result drives it low; when both arrive in the same cycle, the result wins.
- R10: A mode write during a calibration aborts it and restarts the sequence for the new code. If the abort falls before the sixth tick, neither coefficient changes.
- R11: Codes other than 100 and 101 read back as written and run normal conversion: the first result comes after three ticks, then one result per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Mode code to write |
| bipolar | input | 1 | 1 selects offset-binary output coding |
| out_tick | input | 1 | One-cycle pulse per output-rate period |
| mod_tick | input | 1 | One-cycle pulse per modulator cycle |
| raw_data | input | W | Filtered result, valid with `out_tick` |
| filt_sync | input | 1 | Filter restart request |
| rd_strobe | input | 1 | Data register read strobe |
| drdy_n | output | 1 | Data ready, active low |
| mode_rd | output | 3 | Mode code readback |
| meas_src | output | 2 | Source select: 0 input, 1 internal zero, 2 reference |
| zs_coef | output | W | Zero-scale coefficient |
| fs_coef | output | W | Full-scale coefficient |
| data_out | output | W | Offset-corrected result |

## Verification
The hardest situation to reach is an abort during the full-scale phase. By then a zero-scale value has been measured but must not be committed. The stimulus reaches it by running the three zero-scale ticks and one full-scale tick, then rewriting the mode. It then confirms that both coefficients keep their earlier values and that the restarted sequence commits only the new measurements.

A second hard case is the tick on which a read strobe and a background result coincide. The bench places the strobe on exactly that tick.

// File: rtl/sdcal_pkg.sv
package sdcal_pkg;
  typedef enum logic [1:0] {
    ST_CONV = 2'd0,
    ST_SOZ  = 2'd1,
    ST_SOF  = 2'd2,
    ST_BGZ  = 2'd3
  } cal_state_t;

  localparam logic [2:0] MODE_NORM = 3'b000;
  localparam logic [2:0] MODE_SOFF = 3'b100;
  localparam logic [2:0] MODE_BG   = 3'b101;

  localparam logic [1:0] SRC_AIN  = 2'd0;
  localparam logic [1:0] SRC_ZERO = 2'd1;
  localparam logic [1:0] SRC_REF  = 2'd2;
endpackage

// File: rtl/sdcal_ctrl.sv
module sdcal_ctrl
  import sdcal_pkg::*;
#(
  parameter int STEP_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [2:0] mode_wdata,
  input  logic       out_tick,
  input  logic       filt_sync,
  output logic [2:0] mode_q,
  output logic [1:0] src,
  output logic       zs_sh_ld,
  output logic       so_commit,
  output logic       bg_ld,
  output logic       res_valid
);
  localparam int CW = $clog2(STEP_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEP_TICKS - 1);

  cal_state_t st_q;
  logic [CW-1:0] cnt_q;
  logic settled_q;
  logic bg_act, sync_eff, adv, last;

  assign bg_act   = (mode_q == MODE_BG);
  assign sync_eff = filt_sync && !bg_act && !mode_wr;
  assign adv      = out_tick && !mode_wr && !sync_eff;
  assign last     = (cnt_q == LAST);

  assign zs_sh_ld  = adv && last && (st_q == ST_SOZ);
  assign so_commit = adv && last && (st_q == ST_SOF);
  assign bg_ld     = adv && last && (st_q == ST_BGZ);
  assign res_valid = adv && (st_q == ST_CONV) && (settled_q || last);

  always_comb begin
    case (st_q)
      ST_SOF:  src = SRC_REF;
      ST_BGZ:  src = SRC_ZERO;
      default: src = SRC_AIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_CONV;
      cnt_q     <= '0;
      settled_q <= 1'b0;
      mode_q    <= MODE_NORM;
    end else if (mode_wr) begin
      mode_q    <= mode_wdata;
      cnt_q     <= '0;
      settled_q <= 1'b0;
      if (mode_wdata == MODE_SOFF)    st_q <= ST_SOZ;
      else if (mode_wdata == MODE_BG) st_q <= ST_BGZ;
      else                            st_q <= ST_CONV;
    end else if (sync_eff) begin
      cnt_q     <= '0;
      settled_q <= 1'b0;
    end else if (out_tick) begin
      case (st_q)
        ST_SOZ: begin
          if (last) begin
            st_q  <= ST_SOF;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_SOF: begin
          if (last) begin
            st_q      <= ST_CONV;
            cnt_q     <= '0;
            settled_q <= 1'b0;
            mode_q    <= MODE_NORM;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_BGZ: begin
          if (last) begin
            st_q  <= ST_CONV;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (!settled_q) begin
            if (last) begin
              cnt_q <= '0;
              if (bg_act) st_q <= ST_BGZ;
              else        settled_q <= 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    so_commit |=> (mode_q == MODE_NORM)); // R2
  AST_BG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bg_act && !mode_wr) |=> (mode_q == MODE_BG)); // R5
  AST_NO_RES_IN_CAL: assert property (@(posedge clk) disable iff (rst)
    (src != SRC_AIN) |-> !res_valid); // R2
endmodule

// File: rtl/sdcal_coef.sv
module sdcal_coef #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic         zs_sh_ld,
  input  logic         so_commit,
  input  logic         bg_ld,
  output logic [W-1:0] zs_q,
  output logic [W-1:0] fs_q
);
  localparam logic [W-1:0] FS_UNITY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] zs_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      zs_sh <= '0;
      zs_q  <= '0;
      fs_q  <= FS_UNITY;
    end else begin
      if (zs_sh_ld) zs_sh <= raw;
      if (so_commit) begin
        zs_q <= zs_sh;
        fs_q <= raw;
      end else if (bg_ld) begin
        zs_q <= raw;
      end
    end
  end

  AST_FS_ONLY_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !so_commit |=> $stable(fs_q)); // R5
  AST_ZS_ONLY_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!so_commit && !bg_ld) |=> $stable(zs_q)); // R10
endmodule

// File: rtl/sdcal_corr.sv
module sdcal_corr #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         res_valid,
  input  logic         bipolar,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] zs,
  output logic [W-1:0] data_q
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] MID  = XW'(1) <<< (W - 1);
  localparam logic signed [XW-1:0] MAXV = (XW'(1) <<< W) - XW'(1);

  logic signed [XW-1:0] diff;
  logic [W-1:0] clamped;

  always_comb begin
    diff = $signed({2'b00, raw}) - $signed({2'b00, zs});
    if (bipolar) diff = diff + MID;
    if (diff < 0)         clamped = '0;
    else if (diff > MAXV) clamped = '1;
    else                  clamped = diff[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)            data_q <= '0;
    else if (res_valid) data_q <= clamped;
  end

  AST_UNI_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !bipolar && (raw < zs)) |=> (data_q == '0)); // R7
endmodule

// File: rtl/sdcal_rdy.sv
module sdcal_rdy (
  input  logic clk,
  input  logic rst,
  input  logic mode_wr,
  input  logic mod_tick,
  input  logic rd_strobe,
  input  logic res_valid,
  output logic drdy_n
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy_n <= 1'b1;
      pend_q <= 1'b0;
    end else if (res_valid) begin
      drdy_n <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (mode_wr)                 pend_q <= 1'b1;
      else if (mod_tick && pend_q) pend_q <= 1'b0;
      if (rd_strobe || (mod_tick && pend_q && !mode_wr)) drdy_n <= 1'b1;
    end
  end

  AST_RD_RAISES: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !res_valid) |=> drdy_n); // R9
  AST_RES_LOWERS: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !drdy_n); // R9
  AST_PEND_RISE: assert property (@(posedge clk) disable iff (rst)
    (pend_q && mod_tick && !res_valid && !mode_wr) |=> drdy_n); // R4
endmodule

// File: rtl/sdcal_seq.sv
module sdcal_seq #(
  parameter int W          = 24,
  parameter int STEP_TICKS = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_wr,
  input  logic [2:0]   mode_wdata,
  input  logic         bipolar,
  input  logic         out_tick,
  input  logic         mod_tick,
  input  logic [W-1:0] raw_data,
  input  logic         filt_sync,
  input  logic         rd_strobe,
  output logic         drdy_n,
  output logic [2:0]   mode_rd,
  output logic [1:0]   meas_src,
  output logic [W-1:0] zs_coef,
  output logic [W-1:0] fs_coef,
  output logic [W-1:0] data_out
);
  logic zs_sh_ld, so_commit, bg_ld, res_valid;

  sdcal_ctrl #(.STEP_TICKS(STEP_TICKS)) ctrl_i (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .out_tick(out_tick), .filt_sync(filt_sync), .mode_q(mode_rd),
    .src(meas_src), .zs_sh_ld(zs_sh_ld), .so_commit(so_commit),
    .bg_ld(bg_ld), .res_valid(res_valid)
  );

  sdcal_coef #(.W(W)) coef_i (
    .clk(clk), .rst(rst), .raw(raw_data), .zs_sh_ld(zs_sh_ld),
    .so_commit(so_commit), .bg_ld(bg_ld), .zs_q(zs_coef), .fs_q(fs_coef)
  );

  sdcal_corr #(.W(W)) corr_i (
    .clk(clk), .rst(rst), .res_valid(res_valid), .bipolar(bipolar),
    .raw(raw_data), .zs(zs_coef), .data_q(data_out)
  );

  sdcal_rdy rdy_i (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mod_tick(mod_tick),
    .rd_strobe(rd_strobe), .res_valid(res_valid), .drdy_n(drdy_n)
  );

  AST_BG_NO_FS: assert property (@(posedge clk) disable iff (rst)
    (mode_rd == 3'b101 && !mode_wr) |=> $stable(fs_coef)); // R5
endmodule

// File: tb/sdcal_seq_tb_top.sv
module sdcal_seq_tb_top;
  localparam int W = 24;
  localparam logic [W-1:0] MID = 24'h800000;

  logic clk = 0, rst = 1;
  logic mode_wr = 0, bipolar = 0, out_tick = 0, mod_tick = 0;
  logic filt_sync = 0, rd_strobe = 0;
  logic [2:0] mode_wdata = 0;
  logic [W-1:0] raw_data = 0;
  logic drdy_n;
  logic [2:0] mode_rd;
  logic [1:0] meas_src;
  logic [W-1:0] zs_coef, fs_coef, data_out;

  int total = 0, bad = 0;
  logic [W-1:0] exp_q[$];
  logic drdy_prev = 1;

  always #2 clk = ~clk;

  sdcal_seq #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .bipolar(bipolar), .out_tick(out_tick), .mod_tick(mod_tick),
    .raw_data(raw_data), .filt_sync(filt_sync), .rd_strobe(rd_strobe),
    .drdy_n(drdy_n), .mode_rd(mode_rd), .meas_src(meas_src),
    .zs_coef(zs_coef), .fs_coef(fs_coef), .data_out(data_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: each falling edge of drdy_n pops one expected result
  always @(negedge clk) begin
    if (!rst && drdy_prev && !drdy_n) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3/R9: unexpected result actual=%0h expected=none", data_out);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        if (data_out !== e) begin
          bad++;
          $display("FAIL R7/R8: data_out actual=%0h expected=%0h", data_out, e);
        end
      end
    end
    drdy_prev <= drdy_n;
  end

  task automatic tick(logic [W-1:0] v, bit rd = 0);
    @(negedge clk); out_tick = 1; raw_data = v; rd_strobe = rd;
    @(negedge clk); out_tick = 0; rd_strobe = 0;
    @(negedge clk);
  endtask
  task automatic wr_mode(logic [2:0] m);
    @(negedge clk); mode_wr = 1; mode_wdata = m;
    @(negedge clk); mode_wr = 0;
  endtask
  task automatic pulse_mod();
    @(negedge clk); mod_tick = 1; @(negedge clk); mod_tick = 0;
  endtask
  task automatic do_rd();
    @(negedge clk); rd_strobe = 1; @(negedge clk); rd_strobe = 0;
  endtask
  task automatic do_sync();
    @(negedge clk); filt_sync = 1; @(negedge clk); filt_sync = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 mode", mode_rd, 0);
    check("R1 zs", zs_coef, 0);
    check("R1 fs", fs_coef, MID);
    check("R1 drdy", drdy_n, 1);
    check("R1 data", data_out, 0);

    // R11 normal conversion: settle 3 ticks then one per tick
    tick(100); tick(200);
    check("R11 no early result", drdy_n, 1);
    exp_q.push_back(300); tick(300);
    do_rd();
    check("R9 read raises", drdy_n, 1);
    exp_q.push_back(500); tick(500);
    check("R11 per-tick result", drdy_n, 0);

    // R4 delayed rise with drdy low at write
    wr_mode(3'b100);
    repeat (3) @(negedge clk);
    check("R4 held low before mod tick", drdy_n, 0);
    pulse_mod();
    check("R4 high after mod tick", drdy_n, 1);

    // R2 system-offset calibration
    check("R2 src zs phase", meas_src, 0);
    tick(1000); tick(1001); tick(1010);
    check("R2 src fs phase", meas_src, 2);
    check("R10 zs not committed yet", zs_coef, 0);
    tick(7000); tick(7001); tick(7777);
    check("R2 mode cleared", mode_rd, 0);
    check("R2 zs", zs_coef, 1010);
    check("R2 fs", fs_coef, 7777);
    check("R3 high at 6", drdy_n, 1);
    tick(1100); tick(1100);
    check("R3 high at 8", drdy_n, 1);
    exp_q.push_back(5); tick(1015);
    check("R3 low at 9", drdy_n, 0);

    // R7 unipolar floor
    do_rd();
    exp_q.push_back(0); tick(1000);
    do_rd();

    // R8 bipolar coding and clamp
    bipolar = 1;
    exp_q.push_back(MID + 5); tick(1015); do_rd();
    exp_q.push_back(MID - 1010); tick(0); do_rd();
    exp_q.push_back(24'hFFFFFF); tick(24'hFFFFFF); do_rd();

    // R10 abort in full-scale phase
    wr_mode(3'b100); pulse_mod();
    tick(2000); tick(2000); tick(2000); tick(5000);
    wr_mode(3'b100);
    check("R10 zs kept", zs_coef, 1010);
    check("R10 fs kept", fs_coef, 7777);
    check("R10 mode restarted", mode_rd, 3'b100);
    check("R10 src restart", meas_src, 0);
    tick(3000); tick(3000); tick(3000);
    tick(9000); tick(9000); tick(9000);
    check("R10 new zs", zs_coef, 3000);
    check("R10 new fs", fs_coef, 9000);
    tick(3000); tick(3000);
    exp_q.push_back(MID); tick(3000); do_rd();

    // R6 sync restarts settling in normal mode
    exp_q.push_back(MID + 1); tick(3001); do_rd();
    do_sync();
    tick(3002); tick(3003);
    check("R6 sync restarts count", drdy_n, 1);
    exp_q.push_back(MID + 5); tick(3005); do_rd();

    // R5 background calibration
    bipolar = 0;
    wr_mode(3'b101); pulse_mod();
    check("R5 mode", mode_rd, 3'b101);
    check("R5 src zero", meas_src, 1);
    tick(50); tick(50); tick(40);
    check("R5 zs refresh", zs_coef, 40);
    check("R5 src input", meas_src, 0);
    do_sync();
    tick(100); tick(100);
    check("R6 sync ignored in bg", drdy_n, 1);
    exp_q.push_back(100); tick(140);
    check("R5 result after 6", drdy_n, 0);
    do_rd();
    check("R5 src zero again", meas_src, 1);
    tick(60); tick(60); tick(70);
    check("R5 zs refresh 2", zs_coef, 70);
    tick(170); tick(170);
    exp_q.push_back(100); tick(170, 1);
    check("R9 result wins over read", drdy_n, 0);
    check("R5 fs untouched", fs_coef, 9000);
    check("R5 mode stays", mode_rd, 3'b101);

    // R11 other code reads back and converts normally
    wr_mode(3'b011); pulse_mod();
    check("R11 readback", mode_rd, 3'b011);
    check("R11 src", meas_src, 0);
    tick(10); tick(10);
    exp_q.push_back(0); tick(20);
    do_rd();
    repeat (4) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule